// File: doc/BRIEF.md
# Streaming Merge Sorter for Reliability Lists

This block puts a serially arriving block of `NM` (reliability, tag) pairs into increasing reliability order. A smaller reliability value means a more likely symbol, so the output list starts with the best candidate. The tag travels with its key and is never altered. The block is meant to sit behind a stage that produces an unordered candidate list, one entry per clock, and to pass the ordered list on at the same rate.

Sorting is done by a chain of `ceil(log2(NM))` merge stages. Stage `i` takes two ordered runs of length `2^(i-1)`, back to back, and emits one ordered run of length `2^i`. The first run of a pair is written to a head FIFO that is twice the run length. The second run goes to a tail FIFO. A selector pops the smaller of the two heads, and on a tie it takes the head FIFO.

A stage starts emitting in the cycle after the first element of the second run arrives. The head FIFO can therefore take the next pair's first run while the current merge is still draining. When `NM` is not a power of two, an input feeder fills each block up to `PADN = 2^ceil(log2(NM))` slots with pad entries. Each pad carries the largest key and a pad marker. An output trimmer drops the pads and marks the last real element.

The feeder is a state machine with three states:
- `FEED_IDLE` waits for a block. It moves to `FEED_LOAD` on the first valid element, and that element passes straight through.
- `FEED_LOAD` forwards elements. After the `NM`-th element it moves to `FEED_PAD`, or back to `FEED_IDLE` when `NM` is a power of two.
- `FEED_PAD` inserts pads. After slot `PADN-1` it returns to `FEED_IDLE`.

Each merge stage has two states:
- `MRG_WAIT` is idle. It moves to `MRG_RUN` when the first element of a second run is written.
- `MRG_RUN` pops one element per cycle. It returns to `MRG_WAIT` after `2^i` pops, unless a new second run starts in that same cycle, in which case it stays in `MRG_RUN`.

Top module: `llr_merge_sorter`

## Requirements
- R1: Within each block, `out_key` never decreases from one output element to the next.
- R2: The output of a block holds exactly the (key, tag) pairs presented for that block. Pairs with equal keys leave in the order they were presented.
- R3: Each block yields exactly `NM` output elements. Pad entries never appear on the output. Real elements whose key equals the largest encodable value, all ones over `KEY_W` bits, are still emitted, ahead of any pad.
- R4: `out_last` is high together with the `NM`-th output element of each block and low at all other times.
- R5: The first output element of a block appears `LAT` cycles after the cycle in which the block's first element is presented, where `LAT` is the sum over stages `i = 1..ceil(log2 NM)` of `2^(i-1)+2` (23 for `NM = 12`). The remaining elements follow on consecutive cycles, and `out_valid` is low in every other cycle.
- R6: A block is presented on `NM` consecutive cycles with `in_valid` high. The next block may start `PADN` cycles after the previous start, with no idle cycle between blocks, or any number of cycles later. Every block is sorted independently and nothing is lost or overwritten.
- R7: During the `PADN-NM` cycles that follow a block's last element, `in_valid`, `in_key` and `in_tag` have no effect on any output.
- R8: While reset is asserted, and afterwards until a block's first output is due, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input element present this cycle |
| in_key | input | KEY_W | Reliability value of the input element (smaller is better) |
| in_tag | input | TAG_W | Symbol tag carried with the key |
| out_valid | output | 1 | Ordered output element present this cycle |
| out_key | output | KEY_W | Reliability value of the output element |
| out_tag | output | TAG_W | Tag of the output element |
| out_last | output | 1 | Marks the final element of a block |

## Verification
Some properties are checked by assertions on every cycle:
- each merge stage's run is ordered;
- neither FIFO is popped while empty or filled beyond its depth;
- a new merge never starts before the previous one has made its final pop;
- the feeder always sees a gapless block;
- pads only ever occupy the trailing slots of a block.

Other behaviours can only be shown by the bench's scenarios, comparing against a reference model on every cycle:
- that the output is exactly a stable permutation of the input;
- that the first output lands on the stated cycle;
- that junk driven during pad slots changes nothing;
- that blocks run back to back, or with random gaps, without interfering with each other.

// File: rtl/lsort_pkg.sv
`timescale 1ns/1ps
package lsort_pkg;

    typedef enum logic [1:0] {
        FEED_IDLE = 2'd0,
        FEED_LOAD = 2'd1,
        FEED_PAD  = 2'd2
    } feed_state_t;

    typedef enum logic {
        MRG_WAIT = 1'b0,
        MRG_RUN  = 1'b1
    } mrg_state_t;

    // Number of merge stages for a block of nm elements
    function automatic int stage_count(input int nm);
        return (nm < 2) ? 1 : $clog2(nm);
    endfunction

endpackage

// File: rtl/lsort_pad_feed.sv
`timescale 1ns/1ps
// Element layout: {key, pad, tag}; the ordering key is {key, pad}.
module lsort_pad_feed
    import lsort_pkg::*;
#(
    parameter int EW    = 13,
    parameter int TAG_W = 6,
    parameter int NM    = 12,
    parameter int PADN  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [EW-1:0] in_elem,
    output logic          o_valid,
    output logic [EW-1:0] o_elem
);
    localparam int SW    = (PADN < 2) ? 1 : $clog2(PADN);
    localparam int KW    = EW - TAG_W - 1;
    localparam bit HASPAD = (PADN > NM);

    feed_state_t state, state_n;
    logic [SW-1:0] slot;

    wire [EW-1:0] pad_elem = {{KW{1'b1}}, 1'b1, {TAG_W{1'b0}}};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FEED_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            FEED_IDLE: if (in_valid) state_n = FEED_LOAD;
            FEED_LOAD: if (slot == SW'(NM-1)) state_n = HASPAD ? FEED_PAD : FEED_IDLE;
            FEED_PAD:  if (slot == SW'(PADN-1)) state_n = FEED_IDLE;
            default:   state_n = FEED_IDLE;
        endcase
    end

    // slot counter within the padded block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else begin
            unique case (state)
                FEED_IDLE: slot <= in_valid ? SW'(1) : '0;
                FEED_LOAD,
                FEED_PAD:  slot <= (state_n == FEED_IDLE) ? '0 : slot + SW'(1);
                default:   slot <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        o_valid = 1'b0;
        o_elem  = in_elem;
        unique case (state)
            FEED_IDLE: begin o_valid = in_valid; o_elem = in_elem;  end
            FEED_LOAD: begin o_valid = 1'b1;     o_elem = in_elem;  end
            FEED_PAD:  begin o_valid = 1'b1;     o_elem = pad_elem; end
            default:   begin o_valid = 1'b0;     o_elem = in_elem;  end
        endcase
    end

    // R6: a block arrives without gaps
    assert_gapless_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FEED_LOAD) |-> in_valid);

    // R7: pad slots forward only pad entries
    assert_pad_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FEED_PAD) |-> (o_valid && o_elem[TAG_W]));

endmodule

// File: rtl/lsort_merge_stage.sv
`timescale 1ns/1ps
module lsort_merge_stage
    import lsort_pkg::*;
#(
    parameter int EW    = 13,
    parameter int TAG_W = 6,
    parameter int SUB   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_valid,
    input  logic [EW-1:0] i_elem,
    output logic          o_valid,
    output logic [EW-1:0] o_elem
);
    localparam int HD  = 2 * SUB;
    localparam int HAW = $clog2(HD);
    localparam int LD  = (SUB < 2) ? 2 : SUB;
    localparam int LAW = $clog2(LD);
    localparam int CKW = EW - TAG_W;

    logic [EW-1:0] hmem [HD];
    logic [EW-1:0] lmem [LD];
    logic [HAW:0]  hwp, hrp;
    logic [LAW:0]  lwp, lrp;
    logic [HAW-1:0] in_idx, hcnt, lcnt;
    mrg_state_t state, state_n;

    logic to_l, start_ev, h_done, l_done, take_h, pop, last_pop;
    logic [EW-1:0] hhead, lhead;
    logic [HAW:0]  tot;

    assign to_l     = in_idx[HAW-1];
    assign start_ev = i_valid && (in_idx == HAW'(SUB));
    assign hhead    = hmem[hrp[HAW-1:0]];
    assign lhead    = lmem[lrp[LAW-1:0]];
    assign h_done   = (hcnt == HAW'(SUB));
    assign l_done   = (lcnt == HAW'(SUB));
    assign tot      = {1'b0, hcnt} + {1'b0, lcnt};

    // selector: ties go to the head FIFO (first run)
    always_comb begin
        if (l_done)      take_h = 1'b1;
        else if (h_done) take_h = 1'b0;
        else             take_h = (hhead[EW-1:TAG_W] <= lhead[EW-1:TAG_W]);
    end

    assign pop      = (state == MRG_RUN) && !(h_done && l_done);
    assign last_pop = pop && (tot == (HAW+1)'(2*SUB-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MRG_WAIT;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            MRG_WAIT: if (start_ev) state_n = MRG_RUN;
            MRG_RUN:  if (start_ev) state_n = MRG_RUN;
                      else if (last_pop) state_n = MRG_WAIT;
            default:  state_n = MRG_WAIT;
        endcase
    end

    // FIFO storage
    always_ff @(posedge clk) begin
        if (i_valid && !to_l) hmem[hwp[HAW-1:0]] <= i_elem;
        if (i_valid &&  to_l) lmem[lwp[LAW-1:0]] <= i_elem;
    end

    // pointers and run counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hwp <= '0; hrp <= '0; lwp <= '0; lrp <= '0;
            in_idx <= '0; hcnt <= '0; lcnt <= '0;
        end else begin
            if (i_valid) in_idx <= in_idx + HAW'(1);
            if (i_valid && !to_l) hwp <= hwp + (HAW+1)'(1);
            if (i_valid &&  to_l) lwp <= lwp + (LAW+1)'(1);
            if (pop &&  take_h) hrp <= hrp + (HAW+1)'(1);
            if (pop && !take_h) lrp <= lrp + (LAW+1)'(1);
            if (start_ev) begin
                hcnt <= '0;
                lcnt <= '0;
            end else if (pop) begin
                if (take_h) hcnt <= hcnt + HAW'(1);
                else        lcnt <= lcnt + HAW'(1);
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_elem  <= '0;
        end else begin
            o_valid <= pop;
            if (pop) o_elem <= take_h ? hhead : lhead;
        end
    end

    // checker state: position within the emitted run, previous key
    logic [HAW-1:0] opos;
    logic [CKW-1:0] prev_k;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opos   <= '0;
            prev_k <= '0;
        end else if (o_valid) begin
            opos   <= opos + HAW'(1);
            prev_k <= o_elem[EW-1:TAG_W];
        end
    end

    assert_run_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && (opos != '0)) |-> (o_elem[EW-1:TAG_W] >= prev_k));

    assert_h_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && take_h) |-> (hwp != hrp));

    assert_l_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !take_h) |-> (lwp != lrp));

    assert_h_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hwp - hrp) <= (HAW+1)'(HD));

    assert_l_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lwp - lrp) <= (LAW+1)'(SUB));

    assert_no_merge_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && (state == MRG_RUN)) |-> last_pop);

endmodule

// File: rtl/lsort_out_trim.sv
`timescale 1ns/1ps
module lsort_out_trim #(
    parameter int EW    = 13,
    parameter int TAG_W = 6,
    parameter int NM    = 12,
    parameter int PADN  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_valid,
    input  logic [EW-1:0]    i_elem,
    output logic             out_valid,
    output logic [EW-TAG_W-2:0] out_key,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_last
);
    localparam int TW = (PADN < 2) ? 1 : $clog2(PADN);

    logic [TW-1:0] cnt;
    logic          is_pad;

    assign is_pad = i_elem[TAG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (i_valid) cnt <= (cnt == TW'(PADN-1)) ? '0 : cnt + TW'(1);
    end

    always_comb begin
        out_valid = i_valid && !is_pad;
        out_last  = i_valid && (cnt == TW'(NM-1));
        out_key   = i_elem[EW-1:TAG_W+1];
        out_tag   = i_elem[TAG_W-1:0];
    end

    assert_real_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && (cnt < TW'(NM))) |-> !is_pad);

    assert_pad_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && (cnt >= TW'(NM))) |-> is_pad);

endmodule

// File: rtl/llr_merge_sorter.sv
`timescale 1ns/1ps
module llr_merge_sorter
    import lsort_pkg::*;
#(
    parameter int KEY_W = 6,
    parameter int TAG_W = 6,
    parameter int NM    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_key,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_last
);
    localparam int NSTG = stage_count(NM);
    localparam int PADN = 1 << NSTG;
    localparam int EW   = KEY_W + 1 + TAG_W;

    logic          sv [NSTG+1];
    logic [EW-1:0] sd [NSTG+1];

    lsort_pad_feed #(.EW(EW), .TAG_W(TAG_W), .NM(NM), .PADN(PADN)) u_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_elem ({in_key, 1'b0, in_tag}),
        .o_valid (sv[0]),
        .o_elem  (sd[0])
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        lsort_merge_stage #(.EW(EW), .TAG_W(TAG_W), .SUB(1 << g)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .i_valid(sv[g]),
            .i_elem (sd[g]),
            .o_valid(sv[g+1]),
            .o_elem (sd[g+1])
        );
    end

    lsort_out_trim #(.EW(EW), .TAG_W(TAG_W), .NM(NM), .PADN(PADN)) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_valid  (sv[NSTG]),
        .i_elem   (sd[NSTG]),
        .out_valid(out_valid),
        .out_key  (out_key),
        .out_tag  (out_tag),
        .out_last (out_last)
    );

    assert_last_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: tb/sim_llr_merge_sorter.sv
`timescale 1ns/1ps
module sim_llr_merge_sorter;
    localparam int KEY_W = 6;
    localparam int TAG_W = 6;
    localparam int NM    = 12;
    localparam int NSTG  = (NM < 2) ? 1 : $clog2(NM);
    localparam int PADN  = 1 << NSTG;
    localparam int KMAX  = (1 << KEY_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [KEY_W-1:0] in_key = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic out_valid, out_last;
    logic [KEY_W-1:0] out_key;
    logic [TAG_W-1:0] out_tag;

    always #4 clk = ~clk;   // 125 MHz

    llr_merge_sorter #(.KEY_W(KEY_W), .TAG_W(TAG_W), .NM(NM)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key), .in_tag(in_tag),
        .out_valid(out_valid), .out_key(out_key), .out_tag(out_tag), .out_last(out_last)
    );

    typedef struct { int cyc; int key; int tag; bit last; } exp_t;
    exp_t q[$];
    int ncyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int lat;
    string phase = "reset R8";
    int bk [NM];
    int bt [NM];

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", req, phase, ncyc, act, expv);
        end
    endtask

    task automatic check_now();
        if (q.size() > 0 && q[0].cyc == ncyc) begin
            exp_t e = q.pop_front();
            chk(out_valid === 1'b1, "R5 valid", int'(out_valid), 1);
            chk(int'(out_key) == e.key, "R1 key", int'(out_key), e.key);
            chk(int'(out_tag) == e.tag, "R2 tag", int'(out_tag), e.tag);
            chk(out_last === e.last, "R4 last", int'(out_last), int'(e.last));
        end else begin
            chk(out_valid === 1'b0, "R3/R5 idle valid", int'(out_valid), 0);
            chk(out_last === 1'b0, "R4 idle last", int'(out_last), 0);
        end
    endtask

    task automatic step(input bit v, input int k, input int t);
        @(negedge clk);
        check_now();
        in_valid = v;
        in_key   = KEY_W'(k);
        in_tag   = TAG_W'(t);
    endtask

    // stable reference sort of bk/bt, scheduled from the start cycle
    task automatic schedule(input int start);
        int sk [NM];
        int st [NM];
        for (int i = 0; i < NM; i++) begin sk[i] = bk[i]; st[i] = bt[i]; end
        for (int i = 1; i < NM; i++) begin
            int ck = sk[i];
            int ct = st[i];
            int j = i - 1;
            while (j >= 0 && sk[j] > ck) begin
                sk[j+1] = sk[j]; st[j+1] = st[j]; j--;
            end
            sk[j+1] = ck; st[j+1] = ct;
        end
        for (int i = 0; i < NM; i++) begin
            exp_t e;
            e.cyc = start + lat + i; e.key = sk[i]; e.tag = st[i]; e.last = (i == NM-1);
            q.push_back(e);
        end
    endtask

    // junk: drive in_valid high with small keys during the pad slots (R7)
    task automatic send_block(input int gap, input bit junk);
        @(negedge clk);
        check_now();
        schedule(ncyc);
        in_valid = 1'b1; in_key = KEY_W'(bk[0]); in_tag = TAG_W'(bt[0]);
        for (int i = 1; i < NM; i++) step(1'b1, bk[i], bt[i]);
        for (int i = NM; i < PADN; i++) step(junk, 0, i);
        for (int i = 0; i < gap; i++) step(1'b0, 0, 0);
    endtask

    initial begin
        lat = 0;
        for (int i = 1; i <= NSTG; i++) lat += (1 << (i-1)) + 2;

        // R8: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R8 reset valid", int'(out_valid), 0);
            chk(out_last === 1'b0, "R8 reset last", int'(out_last), 0);
        end
        rst_n = 1'b1;
        phase = "post-reset idle R8";
        for (int i = 0; i < 3; i++) step(1'b0, 0, 0);

        // R1 R2: ascending and descending keys
        phase = "ascending R1";
        for (int i = 0; i < NM; i++) begin bk[i] = i * 3; bt[i] = i; end
        send_block(0, 1'b0);
        phase = "descending R1";
        for (int i = 0; i < NM; i++) begin bk[i] = 60 - i * 4; bt[i] = 40 + i; end
        send_block(0, 1'b0);

        // R2: many equal keys, stability
        phase = "equal keys R2";
        for (int i = 0; i < NM; i++) begin bk[i] = 7; bt[i] = i; end
        send_block(2, 1'b0);
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < NM; i++) begin bk[i] = $urandom_range(0, 3); bt[i] = i + 8*b; end
            send_block(0, 1'b0);
        end

        // R3: real elements at the largest key
        phase = "max keys R3";
        for (int i = 0; i < NM; i++) begin bk[i] = KMAX; bt[i] = 63 - i; end
        send_block(1, 1'b0);
        for (int i = 0; i < NM; i++) begin bk[i] = (i % 3 == 0) ? KMAX : i; bt[i] = i; end
        send_block(0, 1'b0);

        // R7: junk driven in the pad slots
        phase = "pad-slot junk R7";
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < NM; i++) begin bk[i] = $urandom_range(10, KMAX); bt[i] = $urandom_range(0, 63); end
            send_block(0, 1'b1);
        end

        // R6: back-to-back random blocks, then random gaps
        phase = "back-to-back R6";
        for (int b = 0; b < 40; b++) begin
            for (int i = 0; i < NM; i++) begin bk[i] = $urandom_range(0, KMAX); bt[i] = $urandom_range(0, 63); end
            send_block(0, b[0]);
        end
        phase = "random gaps R6";
        for (int b = 0; b < 30; b++) begin
            for (int i = 0; i < NM; i++) begin bk[i] = $urandom_range(0, KMAX); bt[i] = $urandom_range(0, 63); end
            send_block($urandom_range(0, 5), 1'b0);
        end

        // drain and confirm every expected element appeared (R3 R5)
        phase = "drain R3";
        for (int i = 0; i < lat + PADN + 8; i++) step(1'b0, 0, 0);
        chk(q.size() == 0, "R3 missing outputs", q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule